// File: doc/BRIEF.md
# Cellular Programming Rule Updater

This block evolves the rules of a small network of Boolean nodes after a fitness round. Every node owns an 8-bit truth table for a three-input function, a fitness score and two neighbour indices. The indices name the nodes that drive the node's two random inputs. Because neighbourhood follows connectivity, it may be asymmetric and non-uniform: a node can be its own neighbour, or name the same node twice.

When started, the block visits the nodes one per clock. For each node it counts the driving neighbours whose fitness is strictly greater than the node's own, and from that count:

- it keeps the rule when the count is zero;
- it copies the fitter neighbour's rule when the count is one;
- it crosses over the two neighbours' rules when the count is two.

Every replaced rule then has one bit flipped. The crossover cut and the flipped bit come from a 16-bit LFSR. All decisions use the rules and fitness as they were at start, and the new rules are committed together at the end.

A second mode fills every rule with pseudo-random values before the first generation. Tables are loaded through a simple write port while the block is idle and are observed through a combinational read port.

Top module: `cp_rule_updater`

## Requirements
- R1: A high `start` while idle begins a run, and `busy` is high from the next cycle until the run ends. `start` while busy is ignored.
- R2: While idle, `cfg_we` writes `cfg_wdata` into the table picked by `cfg_sel` at node `cfg_addr`. The codes are 0 = rule, 1 = fitness, 2 = first neighbour index, 3 = second neighbour index. Writes while busy are ignored. The read port returns all four fields of node `rd_addr` in the same cycle.
- R3: A node with no neighbour whose fitness is strictly greater than its own keeps its rule unchanged.
- R4: A node with exactly one strictly fitter neighbour takes that neighbour's rule with bit `s[5:3]` inverted, where `s` is the LFSR value used for that node.
- R5: A node with two strictly fitter neighbours takes a crossover, then the same one-bit flip as R4. The best parent has the higher fitness; on equal fitness it is the one with the lower node index. With k = `s[2:0]`, bit positions below k come from the other parent and positions k and above come from the best parent.
- R6: Every node of a run is evaluated against the rules and fitness held at start. A rule produced earlier in the run never feeds a later node. All new rules become visible together.
- R7: The LFSR resets to 16'hACE1 and steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. Node i of a run uses the value after i steps from the run's first value. The LFSR advances once per node in both modes and carries its state from one run to the next.
- R8: With `init_mode` high at start, node i's rule becomes `s[7:0]` of the LFSR value it uses, whatever the fitness.
- R9: `done` is high for exactly one cycle, the cycle after the commit. With `start` sampled at clock edge 0, the new rules and `done` appear after edge NODES+1.
- R10: After reset all rules, fitness values and indices read zero, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| init_mode | input | 1 | Run fills rules from the LFSR instead of evolving them |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after commit |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 rule, 1 fitness, 2 neighbour A, 3 neighbour B |
| cfg_addr | input | IDX_W | Node written |
| cfg_wdata | input | DATA_W | Write data, low bits used |
| rd_addr | input | IDX_W | Node read |
| rd_rule | output | 8 | Rule of node `rd_addr` |
| rd_fit | output | FIT_W | Fitness of node `rd_addr` |
| rd_nbr_a | output | IDX_W | First neighbour index of node `rd_addr` |
| rd_nbr_b | output | IDX_W | Second neighbour index of node `rd_addr` |

## Verification
Several fitness and wiring patterns are applied, and each isolates one branch of the update. Equal fitness everywhere exercises only the keep branch. A rising fitness ramp with one self-loop neighbour yields single copies. A ramp with two forward neighbours yields crossovers that chain through the snapshot. An even/odd pattern gives two equally fit neighbours, which separates the tie break by index. A run with writes and a second start injected mid-run shows that the tables stay frozen, and two initialisation runs show that the LFSR continues between runs.

// File: rtl/cp_pkg.sv
package cp_pkg;

    localparam int RULE_IN = 3;
    localparam int RULE_W  = 1 << RULE_IN;
    localparam int SEL_W   = RULE_IN;
    localparam int LFSR_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_COMMIT = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        SEL_RULE = 2'd0,
        SEL_FIT  = 2'd1,
        SEL_NBRA = 2'd2,
        SEL_NBRB = 2'd3
    } table_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/cp_rank.sv
module cp_rank #(
    parameter int FIT_W  = 8,
    parameter int IDX_W  = 3,
    parameter int RULE_W = 8
) (
    input  logic [FIT_W-1:0]  own_fit,
    input  logic [FIT_W-1:0]  fit_a,
    input  logic [FIT_W-1:0]  fit_b,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [RULE_W-1:0] rule_a,
    input  logic [RULE_W-1:0] rule_b,
    output logic [1:0]        fitter_cnt,
    output logic [RULE_W-1:0] best_rule,
    output logic [RULE_W-1:0] other_rule
);

    logic a_up, b_up, a_first;

    always_comb begin
        a_up       = fit_a > own_fit;
        b_up       = fit_b > own_fit;
        fitter_cnt = {1'b0, a_up} + {1'b0, b_up};
        a_first    = (fit_a > fit_b) || ((fit_a == fit_b) && (idx_a <= idx_b));
        best_rule  = rule_a;
        other_rule = rule_b;
        if (fitter_cnt == 2'd1) begin
            best_rule  = a_up ? rule_a : rule_b;
            other_rule = best_rule;
        end else if (fitter_cnt == 2'd2 && !a_first) begin
            best_rule  = rule_b;
            other_rule = rule_a;
        end
    end

endmodule

// File: rtl/cp_recombine.sv
module cp_recombine #(
    parameter int RULE_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic [RULE_W-1:0] own_rule,
    input  logic [RULE_W-1:0] best_rule,
    input  logic [RULE_W-1:0] other_rule,
    input  logic [1:0]        fitter_cnt,
    input  logic [SEL_W-1:0]  cut,
    input  logic [SEL_W-1:0]  flip,
    output logic [RULE_W-1:0] new_rule
);

    logic [RULE_W-1:0] mixed;

    for (genvar b = 0; b < RULE_W; b++) begin : g_bit
        always_comb begin
            mixed[b] = ((fitter_cnt == 2'd2) && (cut > SEL_W'(b))) ? other_rule[b] : best_rule[b];
            if (fitter_cnt == 2'd0)
                new_rule[b] = own_rule[b];
            else
                new_rule[b] = mixed[b] ^ (flip == SEL_W'(b));
        end
    end

endmodule

// File: rtl/cp_rule_updater.sv
module cp_rule_updater #(
    parameter int          NODES = 8,
    parameter int          FIT_W = 8,
    parameter logic [15:0] SEED  = 16'hACE1,
    localparam int IDX_W  = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int RULE_W = cp_pkg::RULE_W,
    localparam int DATA_W = (FIT_W > RULE_W) ? FIT_W : RULE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              init_mode,
    output logic              busy,
    output logic              done,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [RULE_W-1:0] rd_rule,
    output logic [FIT_W-1:0]  rd_fit,
    output logic [IDX_W-1:0]  rd_nbr_a,
    output logic [IDX_W-1:0]  rd_nbr_b
);
    import cp_pkg::*;

    typedef struct packed {
        state_e                        st;
        logic [IDX_W-1:0]              idx;
        logic                          init;
        logic                          done;
        logic [LFSR_W-1:0]             lfsr;
        logic [NODES-1:0][RULE_W-1:0]  rule;
        logic [NODES-1:0][RULE_W-1:0]  nxt;
        logic [NODES-1:0][FIT_W-1:0]   fit;
        logic [NODES-1:0][IDX_W-1:0]   na;
        logic [NODES-1:0][IDX_W-1:0]   nb;
    } regs_t;

    regs_t d, q;

    logic [1:0]        cnt;
    logic [RULE_W-1:0] best_rule, other_rule, eval_rule;
    logic [IDX_W-1:0]  cur_a, cur_b;

    assign cur_a = q.na[q.idx];
    assign cur_b = q.nb[q.idx];

    cp_rank #(.FIT_W(FIT_W), .IDX_W(IDX_W), .RULE_W(RULE_W)) u_rank (
        .own_fit    (q.fit[q.idx]),
        .fit_a      (q.fit[cur_a]),
        .fit_b      (q.fit[cur_b]),
        .idx_a      (cur_a),
        .idx_b      (cur_b),
        .rule_a     (q.rule[cur_a]),
        .rule_b     (q.rule[cur_b]),
        .fitter_cnt (cnt),
        .best_rule  (best_rule),
        .other_rule (other_rule)
    );

    cp_recombine #(.RULE_W(RULE_W), .SEL_W(SEL_W)) u_recombine (
        .own_rule   (q.rule[q.idx]),
        .best_rule  (best_rule),
        .other_rule (other_rule),
        .fitter_cnt (cnt),
        .cut        (q.lfsr[SEL_W-1:0]),
        .flip       (q.lfsr[2*SEL_W-1:SEL_W]),
        .new_rule   (eval_rule)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cfg_we) begin
                    case (table_e'(cfg_sel))
                        SEL_RULE: d.rule[cfg_addr] = cfg_wdata[RULE_W-1:0];
                        SEL_FIT:  d.fit[cfg_addr]  = cfg_wdata[FIT_W-1:0];
                        SEL_NBRA: d.na[cfg_addr]   = cfg_wdata[IDX_W-1:0];
                        default:  d.nb[cfg_addr]   = cfg_wdata[IDX_W-1:0];
                    endcase
                end
                if (start) begin
                    d.st   = ST_RUN;
                    d.idx  = '0;
                    d.init = init_mode;
                end
            end
            ST_RUN: begin
                d.nxt[q.idx] = q.init ? q.lfsr[RULE_W-1:0] : eval_rule;
                d.lfsr       = lfsr_step(q.lfsr);
                if (q.idx == IDX_W'(NODES - 1))
                    d.st = ST_COMMIT;
                else
                    d.idx = q.idx + 1'b1;
            end
            ST_COMMIT: begin
                d.rule = q.nxt;
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.lfsr <= SEED;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign rd_rule  = q.rule[rd_addr];
    assign rd_fit   = q.fit[rd_addr];
    assign rd_nbr_a = q.na[rd_addr];
    assign rd_nbr_b = q.nb[rd_addr];

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R3
    keep_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && !q.init && cnt == 2'd0)
        |=> (q.nxt[$past(q.idx)] == $past(q.rule[q.idx])));

    // R6
    rule_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_COMMIT && !(q.st == ST_IDLE && cfg_we && cfg_sel == 2'd0))
        |=> $stable(q.rule));

    // R7
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.lfsr != '0);

endmodule

// File: tb/cp_rule_updater_bench.sv
module cp_rule_updater_bench;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       init_mode = 1'b0;
    logic       busy, done;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_rule, rd_fit;
    logic [2:0] rd_nbr_a, rd_nbr_b;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0]  m_rule [N];
    logic [7:0]  m_fit  [N];
    logic [2:0]  m_na   [N];
    logic [2:0]  m_nb   [N];
    logic [15:0] m_lfsr = 16'hACE1;

    always #5 clk = ~clk;

    cp_rule_updater u_cp_rule_updater (
        .clk(clk), .rst_n(rst_n), .start(start), .init_mode(init_mode),
        .busy(busy), .done(done), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
        .rd_rule(rd_rule), .rd_fit(rd_fit), .rd_nbr_a(rd_nbr_a), .rd_nbr_b(rd_nbr_b)
    );

    function automatic logic [15:0] m_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(input int sel, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 3'(addr); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(input int i, input int rule, input int fit, input int a, input int b);
        wr(0, i, rule); wr(1, i, fit); wr(2, i, a); wr(3, i, b);
        m_rule[i] = 8'(rule); m_fit[i] = 8'(fit); m_na[i] = 3'(a); m_nb[i] = 3'(b);
    endtask

    // Runs one generation, predicts every rule independently, checks timing and results.
    task automatic run_gen(input bit init, input bit inject, input string name);
        logic [7:0]  exp_rule [N];
        string       tag [N];
        logic [15:0] s;
        int          cycles;
        s = m_lfsr;
        for (int i = 0; i < N; i++) begin
            logic fa, fb, afirst;
            logic [7:0] best, oth;
            int cut, flip;
            cut = int'(s[2:0]); flip = int'(s[5:3]);
            if (init) begin
                exp_rule[i] = s[7:0]; tag[i] = "R8/R7";
            end else begin
                fa = m_fit[m_na[i]] > m_fit[i];
                fb = m_fit[m_nb[i]] > m_fit[i];
                if (!fa && !fb) begin
                    exp_rule[i] = m_rule[i]; tag[i] = "R3/R6";
                end else if (fa != fb) begin
                    exp_rule[i] = (fa ? m_rule[m_na[i]] : m_rule[m_nb[i]]) ^ (8'd1 << flip);
                    tag[i] = "R4/R6/R7";
                end else begin
                    afirst = (m_fit[m_na[i]] > m_fit[m_nb[i]]) ||
                             (m_fit[m_na[i]] == m_fit[m_nb[i]] && m_na[i] <= m_nb[i]);
                    best = afirst ? m_rule[m_na[i]] : m_rule[m_nb[i]];
                    oth  = afirst ? m_rule[m_nb[i]] : m_rule[m_na[i]];
                    for (int b = 0; b < 8; b++)
                        exp_rule[i][b] = (b < cut) ? oth[b] : best[b];
                    exp_rule[i] ^= (8'd1 << flip);
                    tag[i] = "R5/R6/R7";
                end
            end
            s = m_step(s);
        end
        m_lfsr = s;

        @(negedge clk);
        start = 1'b1; init_mode = init;
        @(negedge clk);
        start = 1'b0;
        check({name, " R1 busy after start"}, int'(busy), 1);
        cycles = 1;
        while (!done && cycles < 100) begin
            if (inject && cycles == 3) begin
                cfg_we = 1'b1; cfg_sel = 2'd1; cfg_addr = 3'd0; cfg_wdata = 8'd200; start = 1'b1;
            end else begin
                cfg_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        cfg_we = 1'b0; start = 1'b0;
        check({name, " R9 done latency"}, cycles, N + 2);
        for (int i = 0; i < N; i++) begin
            rd_addr = 3'(i);
            #1;
            check($sformatf("%s %s node %0d rule", name, tag[i], i), int'(rd_rule), int'(exp_rule[i]));
            m_rule[i] = exp_rule[i];
        end
        @(negedge clk);
        check({name, " R9 done single cycle"}, int'(done), 0);
        check({name, " R1 idle after run"}, int'(busy), 0);
        if (inject) begin
            rd_addr = 3'd0;
            #1;
            check({name, " R2 write while busy ignored"}, int'(rd_fit), int'(m_fit[0]));
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < N; i++) begin
            rd_addr = 3'(i);
            #1;
            check($sformatf("R10 rule %0d", i), int'(rd_rule), 0);
            check($sformatf("R10 fit %0d", i), int'(rd_fit), 0);
        end
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
    endtask

    task automatic t_config;
        load(5, 8'h3C, 77, 6, 2);
        rd_addr = 3'd5;
        #1;
        check("R2 rule write", int'(rd_rule), 8'h3C);
        check("R2 fitness write", int'(rd_fit), 77);
        check("R2 nbr a write", int'(rd_nbr_a), 6);
        check("R2 nbr b write", int'(rd_nbr_b), 2);
    endtask

    task automatic t_init;
        for (int i = 0; i < N; i++) load(i, 0, i * 3, i, i);
        run_gen(1'b1, 1'b0, "init-a");
        run_gen(1'b1, 1'b0, "init-b");
    endtask

    task automatic t_keep;
        for (int i = 0; i < N; i++) load(i, 8'h11 * i + 3, 40, (i + 1) % N, (i + 5) % N);
        run_gen(1'b0, 1'b0, "keep");
    endtask

    task automatic t_copy;
        for (int i = 0; i < N; i++) load(i, 8'h25 * i + 7, 10 * i, (i + 1) % N, i);
        run_gen(1'b0, 1'b0, "copy");
    endtask

    task automatic t_cross;
        for (int i = 0; i < N; i++) load(i, 8'h5A ^ (8'h13 * i), i, (i + 1) % N, (i + 2) % N);
        run_gen(1'b0, 1'b0, "cross");
    endtask

    task automatic t_tie;
        for (int i = 0; i < N; i++)
            load(i, 8'hC3 ^ (8'h1F * i), (i % 2 == 0) ? 1 : 9, (i + 3) % N, (i + 1) % N);
        load(2, 8'h0F, 0, 7, 7);
        run_gen(1'b0, 1'b0, "tie");
    endtask

    task automatic t_busy_ignore;
        for (int i = 0; i < N; i++) load(i, 8'h81 + i, 20 + i, (i + 1) % N, (i + 7) % N);
        run_gen(1'b0, 1'b1, "inject");
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_config;
        t_init;
        t_keep;
        t_copy;
        t_cross;
        t_tie;
        t_busy_ignore;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule